// File: doc/BRIEF.md
# RV32 Base Instruction Classifier

This block sorts a 32-bit base-integer instruction word into its encoding format and the arithmetic operation it needs. It reads the 7-bit primary opcode in the low bits first to find the instruction class. Inside a class, the 3-bit and 7-bit sub-selector fields then pick the exact operation, for example add versus subtract. It also raises a flag for any word it does not recognise.

The three register index fields always sit at the same bit positions, so they are sliced out the same way for every word, whatever its format. The block is purely combinational. A pipeline decode stage places it in front of the immediate builder and the register file read ports.

Top module: `rvdec_top`

## Requirements
- R1: Opcode bits 6:0 choose the format code `fmt_o`:
  - 0110011 gives R (1).
  - 0010011, 0000011 and 1100111 give I (2).
  - 0100011 gives S (3).
  - 1100011 gives B (4).
  - 0110111 and 0010111 give U (5).
  - 1101111 gives J (6).
- R2: Any other opcode, including 0000000 (so the all-zeros word), sets `illegal_o`, drives `fmt_o` to 0 and drives `alu_op_o` to ADD (0).
- R3: For every word, `rd_o` equals bits 11:7, `rs1_o` equals bits 19:15 and `rs2_o` equals bits 24:20.
- R4: Register-register class with funct7 (bits 31:25) equal to 0000000 maps funct3 (bits 14:12) as follows: 000 ADD (0), 001 SLL (2), 010 SLT (3), 011 SLTU (4), 100 XOR (5), 101 SRL (6), 110 OR (8), 111 AND (9).
- R5: Register-register class with funct7 0100000 gives SUB (1) for funct3 000 and SRA (7) for funct3 101. Any other funct3 with that funct7, and any funct7 other than 0000000 or 0100000, is illegal.
- R6: Register-immediate class (0010011) uses the R4 map, except that funct3 000 is always ADD. Bits 31:25 are ignored except in two cases:
  - funct3 001 requires 0000000, otherwise the word is illegal.
  - funct3 101 gives SRL for 0000000, SRA for 0100000, and is illegal for anything else.
- R7: Loads give ADD for funct3 000, 001, 010, 100 or 101 and are illegal otherwise. Stores give ADD for funct3 000, 001 or 010 and are illegal otherwise.
- R8: Branches give SUB for funct3 000 and 001, SLT for 100 and 101, and SLTU for 110 and 111. Funct3 010 and 011 are illegal.
- R9: jalr gives ADD with funct3 000 and is illegal otherwise. jal and auipc give ADD. lui gives PASS-B (10). For all three, bits 31:12 are ignored.
- R10: A word rejected by a sub-selector check keeps the format code of its opcode class and drives `alu_op_o` to ADD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to classify |
| fmt_o | output | 3 | Format code: 0 none, 1 R, 2 I, 3 S, 4 B, 5 U, 6 J |
| alu_op_o | output | 4 | ALU operation code |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| illegal_o | output | 1 | Word is not a supported instruction |

## Verification
The assertions check the following invariants on every input change:
- The register indices track their fixed bit positions.
- The all-zeros word is always illegal.
- A zero format code implies the illegal flag.
- Rejected words fall back to ADD.
- SUB, PASS-B and the branch operation set appear only under their own opcode classes.

The exact funct3/funct7 mapping in each class can only be shown by the bench's vector table and directed words. This includes the mixed cases where funct7 is legal for one funct3 and illegal for another.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

   localparam int OPC_W = 7;
   localparam int F3_W  = 3;
   localparam int F7_W  = 7;

   typedef enum logic [2:0] {
      FMT_NONE = 3'd0,
      FMT_R    = 3'd1,
      FMT_I    = 3'd2,
      FMT_S    = 3'd3,
      FMT_B    = 3'd4,
      FMT_U    = 3'd5,
      FMT_J    = 3'd6
   } fmt_e;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_SLL   = 4'd2,
      OP_SLT   = 4'd3,
      OP_SLTU  = 4'd4,
      OP_XOR   = 4'd5,
      OP_SRL   = 4'd6,
      OP_SRA   = 4'd7,
      OP_OR    = 4'd8,
      OP_AND   = 4'd9,
      OP_PASSB = 4'd10
   } aluop_e;

   typedef enum logic [3:0] {
      CL_NONE, CL_REG, CL_IMM, CL_LOAD, CL_JALR,
      CL_STORE, CL_BRANCH, CL_LUI, CL_AUIPC, CL_JAL
   } cls_e;

   localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
   localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
   localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
   localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
   localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
   localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
   localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
   localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

   localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
   localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

endpackage

// File: rtl/rvdec_opclass.sv
module rvdec_opclass
   import rvdec_pkg::*;
(
   input  logic [OPC_W-1:0] opc_i,
   output cls_e             cls_o,
   output fmt_e             fmt_o
);

   // R1 / R2: the primary opcode alone decides class and format
   always_comb begin
      unique case (opc_i)
         OPC_REG:    begin cls_o = CL_REG;    fmt_o = FMT_R;    end
         OPC_IMM:    begin cls_o = CL_IMM;    fmt_o = FMT_I;    end
         OPC_LOAD:   begin cls_o = CL_LOAD;   fmt_o = FMT_I;    end
         OPC_JALR:   begin cls_o = CL_JALR;   fmt_o = FMT_I;    end
         OPC_STORE:  begin cls_o = CL_STORE;  fmt_o = FMT_S;    end
         OPC_BRANCH: begin cls_o = CL_BRANCH; fmt_o = FMT_B;    end
         OPC_LUI:    begin cls_o = CL_LUI;    fmt_o = FMT_U;    end
         OPC_AUIPC:  begin cls_o = CL_AUIPC;  fmt_o = FMT_U;    end
         OPC_JAL:    begin cls_o = CL_JAL;    fmt_o = FMT_J;    end
         default:    begin cls_o = CL_NONE;   fmt_o = FMT_NONE; end
      endcase
   end

endmodule

// File: rtl/rvdec_refine.sv
module rvdec_refine
   import rvdec_pkg::*;
(
   input  cls_e             cls_i,
   input  logic [F3_W-1:0]  f3_i,
   input  logic [F7_W-1:0]  f7_i,
   output aluop_e           op_o,
   output logic             bad_o
);

   aluop_e base_op;
   logic   f7_base;
   logic   f7_alt;

   assign f7_base = (f7_i == F7_BASE);
   assign f7_alt  = (f7_i == F7_ALT);

   // funct3 map shared by the register and immediate arithmetic classes (R4)
   always_comb begin
      unique case (f3_i)
         3'b000:  base_op = OP_ADD;
         3'b001:  base_op = OP_SLL;
         3'b010:  base_op = OP_SLT;
         3'b011:  base_op = OP_SLTU;
         3'b100:  base_op = OP_XOR;
         3'b101:  base_op = OP_SRL;
         3'b110:  base_op = OP_OR;
         default: base_op = OP_AND;
      endcase
   end

   aluop_e raw_op;
   logic   raw_bad;

   always_comb begin
      raw_op  = OP_ADD;
      raw_bad = 1'b0;
      unique case (cls_i)
         CL_REG: begin
            if (f7_base) begin
               raw_op = base_op;
            end else if (f7_alt && f3_i == 3'b000) begin
               raw_op = OP_SUB;
            end else if (f7_alt && f3_i == 3'b101) begin
               raw_op = OP_SRA;
            end else begin
               raw_bad = 1'b1;
            end
         end
         CL_IMM: begin
            raw_op = base_op;
            if (f3_i == 3'b001) begin
               raw_bad = !f7_base;
            end else if (f3_i == 3'b101) begin
               if (f7_alt)        raw_op  = OP_SRA;
               else if (!f7_base) raw_bad = 1'b1;
            end
         end
         CL_LOAD:  raw_bad = (f3_i == 3'b011) || (f3_i[2:1] == 2'b11);
         CL_STORE: raw_bad = (f3_i[2] == 1'b1) || (f3_i == 3'b011);
         CL_BRANCH: begin
            unique case (f3_i[2:1])
               2'b00:   raw_op  = OP_SUB;
               2'b10:   raw_op  = OP_SLT;
               2'b11:   raw_op  = OP_SLTU;
               default: raw_bad = 1'b1;
            endcase
         end
         CL_JALR:  raw_bad = (f3_i != 3'b000);
         CL_LUI:   raw_op  = OP_PASSB;
         CL_AUIPC: raw_op  = OP_ADD;
         CL_JAL:   raw_op  = OP_ADD;
         default:  raw_bad = 1'b1;
      endcase
   end

   // R10: rejected words fall back to ADD
   assign bad_o = raw_bad;
   assign op_o  = raw_bad ? OP_ADD : raw_op;

endmodule

// File: rtl/rvdec_fields.sv
module rvdec_fields
   import rvdec_pkg::*;
#(
   parameter int ILEN   = 32,
   parameter int RIDX_W = 5
) (
   input  logic [ILEN-1:0]             instr_i,
   output logic [2:0][RIDX_W-1:0]      idx_o,
   output logic [F3_W-1:0]             f3_o,
   output logic [F7_W-1:0]             f7_o
);

   localparam int RD_LSB  = OPC_W;
   localparam int F3_LSB  = RD_LSB + RIDX_W;
   localparam int RS1_LSB = F3_LSB + F3_W;
   localparam int RS2_LSB = RS1_LSB + RIDX_W;
   localparam int F7_LSB  = RS2_LSB + RIDX_W;
   localparam int IDX_LSB [3] = '{RD_LSB, RS1_LSB, RS2_LSB};

   // R3: one slicing rule for every format
   for (genvar g = 0; g < 3; g++) begin : g_idx
      assign idx_o[g] = instr_i[IDX_LSB[g] +: RIDX_W];
   end

   assign f3_o = instr_i[F3_LSB +: F3_W];
   assign f7_o = instr_i[F7_LSB +: F7_W];

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
   import rvdec_pkg::*;
#(
   parameter int ILEN   = 32,
   parameter int RIDX_W = 5
) (
   input  logic [ILEN-1:0]   instr_i,
   output logic [2:0]        fmt_o,
   output logic [3:0]        alu_op_o,
   output logic [RIDX_W-1:0] rd_o,
   output logic [RIDX_W-1:0] rs1_o,
   output logic [RIDX_W-1:0] rs2_o,
   output logic              illegal_o
);

   localparam int FIELD_SUM = OPC_W + F3_W + F7_W + 3 * RIDX_W;

   if (FIELD_SUM != ILEN) begin : g_bad_layout
      $error("rvdec_top: field widths do not fill the instruction word");
   end
   if (RIDX_W != 5) begin : g_bad_ridx
      $error("rvdec_top: register index width must be 5");
   end

   cls_e                  cls;
   fmt_e                  fmt;
   aluop_e                op;
   logic                  bad;
   logic [2:0][RIDX_W-1:0] idx;
   logic [F3_W-1:0]       f3;
   logic [F7_W-1:0]       f7;

   rvdec_opclass u_opclass (
      .opc_i (instr_i[OPC_W-1:0]),
      .cls_o (cls),
      .fmt_o (fmt)
   );

   rvdec_fields #(.ILEN(ILEN), .RIDX_W(RIDX_W)) u_fields (
      .instr_i (instr_i),
      .idx_o   (idx),
      .f3_o    (f3),
      .f7_o    (f7)
   );

   rvdec_refine u_refine (
      .cls_i (cls),
      .f3_i  (f3),
      .f7_i  (f7),
      .op_o  (op),
      .bad_o (bad)
   );

   assign fmt_o     = fmt;
   assign alu_op_o  = op;
   assign illegal_o = bad;
   assign rd_o      = idx[0];
   assign rs1_o     = idx[1];
   assign rs2_o     = idx[2];

endmodule

// File: rtl/rvdec_chk.sv
module rvdec_chk
   import rvdec_pkg::*;
#(
   parameter int ILEN   = 32,
   parameter int RIDX_W = 5
) (
   input logic [ILEN-1:0]   instr_i,
   input logic [2:0]        fmt_o,
   input logic [3:0]        alu_op_o,
   input logic [RIDX_W-1:0] rd_o,
   input logic [RIDX_W-1:0] rs1_o,
   input logic [RIDX_W-1:0] rs2_o,
   input logic              illegal_o
);

   always_comb begin
      a_r2_zero_word_illegal: assert (instr_i != '0 || illegal_o)
         else $error("all-zeros word not flagged");
      a_r2_no_format_means_illegal: assert (fmt_o != FMT_NONE || illegal_o)
         else $error("format none without illegal flag");
      a_r3_rd_position: assert (rd_o == instr_i[11:7])
         else $error("rd index misplaced");
      a_r3_rs1_position: assert (rs1_o == instr_i[19:15])
         else $error("rs1 index misplaced");
      a_r3_rs2_position: assert (rs2_o == instr_i[24:20])
         else $error("rs2 index misplaced");
      a_r10_illegal_is_add: assert (!illegal_o || alu_op_o == OP_ADD)
         else $error("illegal word with non-add op");
      a_r9_passb_only_lui: assert (alu_op_o != OP_PASSB || instr_i[6:0] == OPC_LUI)
         else $error("pass-b outside lui");
      a_r5_sub_in_r_or_b: assert (alu_op_o != OP_SUB || fmt_o == FMT_R || fmt_o == FMT_B)
         else $error("sub outside register or branch class");
      a_r8_branch_op_set: assert (fmt_o != FMT_B || illegal_o || alu_op_o == OP_SUB
                                  || alu_op_o == OP_SLT || alu_op_o == OP_SLTU)
         else $error("branch op outside compare set");
   end

endmodule

bind rvdec_top rvdec_chk #(.ILEN(ILEN), .RIDX_W(RIDX_W)) u_chk (
   .instr_i   (instr_i),
   .fmt_o     (fmt_o),
   .alu_op_o  (alu_op_o),
   .rd_o      (rd_o),
   .rs1_o     (rs1_o),
   .rs2_o     (rs2_o),
   .illegal_o (illegal_o)
);

// File: tb/rvdec_top_tb.sv
module rvdec_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0;
   logic [2:0]  fmt;
   logic [3:0]  alu_op;
   logic [4:0]  rd, rs1, rs2;
   logic        illegal;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rvdec_top u_dut (
      .instr_i   (instr),
      .fmt_o     (fmt),
      .alu_op_o  (alu_op),
      .rd_o      (rd),
      .rs1_o     (rs1),
      .rs2_o     (rs2),
      .illegal_o (illegal)
   );

   // {funct7, funct3, opcode, fmt, op, illegal, req}
   localparam logic [28:0] VEC [NVEC] = '{
      // R4 register-register base ops
      {7'h00,3'b000,7'b0110011,3'd1,4'd0,1'b0,4'd4},
      {7'h00,3'b001,7'b0110011,3'd1,4'd2,1'b0,4'd4},
      {7'h00,3'b010,7'b0110011,3'd1,4'd3,1'b0,4'd4},
      {7'h00,3'b011,7'b0110011,3'd1,4'd4,1'b0,4'd4},
      {7'h00,3'b100,7'b0110011,3'd1,4'd5,1'b0,4'd4},
      {7'h00,3'b101,7'b0110011,3'd1,4'd6,1'b0,4'd4},
      {7'h00,3'b110,7'b0110011,3'd1,4'd8,1'b0,4'd4},
      {7'h00,3'b111,7'b0110011,3'd1,4'd9,1'b0,4'd4},
      // R5 alternate funct7
      {7'h20,3'b000,7'b0110011,3'd1,4'd1,1'b0,4'd5},
      {7'h20,3'b101,7'b0110011,3'd1,4'd7,1'b0,4'd5},
      {7'h20,3'b001,7'b0110011,3'd1,4'd0,1'b1,4'd5},
      {7'h20,3'b111,7'b0110011,3'd1,4'd0,1'b1,4'd5},
      {7'h01,3'b000,7'b0110011,3'd1,4'd0,1'b1,4'd5},
      // R6 register-immediate
      {7'h20,3'b000,7'b0010011,3'd2,4'd0,1'b0,4'd6},
      {7'h00,3'b001,7'b0010011,3'd2,4'd2,1'b0,4'd6},
      {7'h20,3'b001,7'b0010011,3'd2,4'd0,1'b1,4'd6},
      {7'h7F,3'b010,7'b0010011,3'd2,4'd3,1'b0,4'd6},
      {7'h55,3'b011,7'b0010011,3'd2,4'd4,1'b0,4'd6},
      {7'h7F,3'b100,7'b0010011,3'd2,4'd5,1'b0,4'd6},
      {7'h00,3'b101,7'b0010011,3'd2,4'd6,1'b0,4'd6},
      {7'h20,3'b101,7'b0010011,3'd2,4'd7,1'b0,4'd6},
      {7'h7F,3'b101,7'b0010011,3'd2,4'd0,1'b1,4'd6},
      {7'h10,3'b110,7'b0010011,3'd2,4'd8,1'b0,4'd6},
      {7'h7F,3'b111,7'b0010011,3'd2,4'd9,1'b0,4'd6},
      // R7 loads and stores
      {7'h7F,3'b000,7'b0000011,3'd2,4'd0,1'b0,4'd7},
      {7'h00,3'b101,7'b0000011,3'd2,4'd0,1'b0,4'd7},
      {7'h00,3'b011,7'b0000011,3'd2,4'd0,1'b1,4'd7},
      {7'h00,3'b110,7'b0000011,3'd2,4'd0,1'b1,4'd7},
      {7'h3C,3'b010,7'b0100011,3'd3,4'd0,1'b0,4'd7},
      {7'h00,3'b011,7'b0100011,3'd3,4'd0,1'b1,4'd7},
      {7'h00,3'b100,7'b0100011,3'd3,4'd0,1'b1,4'd7},
      // R8 branches
      {7'h7F,3'b000,7'b1100011,3'd4,4'd1,1'b0,4'd8},
      {7'h00,3'b001,7'b1100011,3'd4,4'd1,1'b0,4'd8},
      {7'h00,3'b100,7'b1100011,3'd4,4'd3,1'b0,4'd8},
      {7'h00,3'b101,7'b1100011,3'd4,4'd3,1'b0,4'd8},
      {7'h00,3'b110,7'b1100011,3'd4,4'd4,1'b0,4'd8},
      {7'h00,3'b111,7'b1100011,3'd4,4'd4,1'b0,4'd8},
      {7'h00,3'b010,7'b1100011,3'd4,4'd0,1'b1,4'd8},
      {7'h00,3'b011,7'b1100011,3'd4,4'd0,1'b1,4'd8},
      // R9 jumps and upper-immediate
      {7'h40,3'b000,7'b1100111,3'd2,4'd0,1'b0,4'd9},
      {7'h00,3'b001,7'b1100111,3'd2,4'd0,1'b1,4'd9},
      {7'h7F,3'b111,7'b0110111,3'd5,4'd10,1'b0,4'd9},
      {7'h12,3'b011,7'b0010111,3'd5,4'd0,1'b0,4'd9},
      {7'h7F,3'b110,7'b1101111,3'd6,4'd0,1'b0,4'd9},
      // R2 unsupported opcodes
      {7'h00,3'b000,7'b0000000,3'd0,4'd0,1'b1,4'd2},
      {7'h7F,3'b111,7'b1111111,3'd0,4'd0,1'b1,4'd2},
      {7'h00,3'b000,7'b0110001,3'd0,4'd0,1'b1,4'd2},
      {7'h20,3'b000,7'b0110010,3'd0,4'd0,1'b1,4'd2}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h word=0x%08h",
                  req, what, act, exp, instr);
      end
   endtask

   task automatic apply_and_check(input logic [31:0] w, input logic [2:0] e_fmt,
                                  input logic [3:0] e_op, input logic e_ill,
                                  input string req);
      @(posedge clk);
      instr = w;
      @(negedge clk);
      check(req, "fmt", 32'(fmt), 32'(e_fmt));
      check(req, "alu_op", 32'(alu_op), 32'(e_op));
      check(req, "illegal", 32'(illegal), 32'(e_ill));
      // R3 register indices at fixed positions
      check("R3", "rd", 32'(rd), 32'(w[11:7]));
      check("R3", "rs1", 32'(rs1), 32'(w[19:15]));
      check("R3", "rs2", 32'(rs2), 32'(w[24:20]));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (R1 run): actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // reset phase: zero word held, expect R2 illegal / none
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R2", "reset fmt", 32'(fmt), 32'd0);
      check("R2", "reset illegal", 32'(illegal), 32'd1);
      check("R2", "reset alu_op", 32'(alu_op), 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic [28:0] v;
         logic [31:0] w;
         v = VEC[i];
         w = {v[28:22], 5'(i * 3 + 1), 5'(i * 7 + 2), v[21:19], 5'(31 - i), v[18:12]};
         // fmt (R1) / ALU op / illegal (R10 when rejected)
         apply_and_check(w, v[11:9], v[8:5], v[4], $sformatf("R%0d", v[3:0]));
         check("R1", "format vs opcode class", 32'(fmt), 32'(v[11:9]));
      end

      // directed: all-zeros word (R2)
      apply_and_check(32'h0000_0000, 3'd0, 4'd0, 1'b1, "R2");
      // directed: all-ones word, opcode 1111111 (R2)
      apply_and_check(32'hFFFF_FFFF, 3'd0, 4'd0, 1'b1, "R2");
      // directed: rejected sub-selector keeps format, op ADD (R10)
      apply_and_check({7'h20, 5'd31, 5'd31, 3'b110, 5'd31, 7'b0110011}, 3'd1, 4'd0, 1'b1, "R10");
      // directed: extreme register indices on a store (R3)
      apply_and_check({7'h00, 5'd31, 5'd0, 3'b000, 5'd31, 7'b0100011}, 3'd3, 4'd0, 1'b0, "R3");
      // directed: lui ignores upper bits, PASS-B (R9)
      apply_and_check({20'hABCDE, 5'd9, 7'b0110111}, 3'd5, 4'd10, 1'b0, "R9");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule